// File: doc/BRIEF.md
# Vector Floating-Point Classify Unit

This unit sorts the elements of one vector register into IEEE-754 categories. A start pulse captures a source vector, the current destination contents, a per-element mask, an active length and an element width of 16, 32 or 64 bits. The unit then steps through the element indices, one per clock. Each active element below the active length is replaced by a 10-bit one-hot category code, zero-extended to the element width. Elements switched off by the mask keep their old destination value. Every element from the active length up to the register's element capacity is cleared. A one-cycle done pulse marks completion, and the updated register is then held on the output.

The control pins are plain. There is no streaming handshake. Start is sampled only while the unit is idle, and a start that arrives during an operation is dropped. The caller waits for done before it issues the next operation. Elements are packed little-endian: element i occupies bits [i*W +: W] of each vector, where W is the element width.

Top module: `vfc_unit`

## Requirements
- R1: An infinity sets code bit 0 when negative and bit 7 when positive. An infinity is an exponent of all ones with a zero mantissa.
- R2: A zero (exponent and mantissa both zero) sets bit 3 when negative and bit 4 when positive.
- R3: A subnormal (exponent zero, mantissa nonzero) sets bit 2 when negative and bit 5 when positive. A zero is never reported as subnormal.
- R4: Any other finite value is normal and sets bit 1 when negative and bit 6 when positive.
- R5: A NaN (exponent all ones, mantissa nonzero) sets bit 9 when the top mantissa bit is 1 and bit 8 when it is 0, whatever its sign.
- R6: sew_sel encodes the element width: 0 is 16 bits (5-bit exponent), 1 is 32 bits (8-bit exponent) and 2 is 64 bits (11-bit exponent). The code occupies bits [9:0] of its destination element, and all higher bits of that element are zero.
- R7: When vm is 0 and bit i of mask is 0, destination element i keeps its previous value. When vm is 1, every element below vl is classified.
- R8: Every element with index from vl up to vlmax-1 is cleared to zero, where vlmax = VLEN/element width.
- R9: done is high for exactly one cycle, vlmax clock edges after the edge that accepts start. A start raised while an operation is running is ignored and does not affect the result.
- R10: With vl = 0, no element is classified, the whole register is cleared, and done still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| sew_sel | input | 2 | Element width select |
| vl | input | VLW | Active element count |
| vm | input | 1 | 1 = unmasked, 0 = use mask |
| mask | input | VLEN/16 | Per-element enable, bit i for element i |
| src_vec | input | VLEN | Source vector |
| dst_in | input | VLEN | Previous destination contents |
| dst_out | output | VLEN | Updated destination vector |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, assertions check the following. done never lasts two cycles and always follows the final index. The index advances without a break while the unit is busy, whatever start does. A tail element is zero right after its write cycle. A masked-off element is unchanged across its cycle. An active element receives a one-hot code. Only the bench scenarios can show which category bit each encoding produces, across all three widths and both signs, and that the finished register matches a reference. The bench also measures latency, covers the empty-length case, and confirms that a start raised in mid-operation leaves the result intact.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  typedef enum logic [1:0] {
    SEW16 = 2'd0,
    SEW32 = 2'd1,
    SEW64 = 2'd2,
    SEWRS = 2'd3
  } sew_e;

  localparam int CLS_W = 10;

  function automatic int exp_w(input int fmt);
    return (fmt == 0) ? 5 : (fmt == 1) ? 8 : 11;
  endfunction

  function automatic int man_w(input int fmt);
    return (fmt == 0) ? 10 : (fmt == 1) ? 23 : 52;
  endfunction

  function automatic logic [1:0] width_shift(input sew_e s);
    return (s == SEWRS) ? 2'd2 : 2'(s);
  endfunction
endpackage

// File: rtl/vfc_classify.sv
module vfc_classify #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] x,
  output logic [9:0]     cls
);
  logic          sgn;
  logic [EW-1:0] ex;
  logic [MW-1:0] mn;
  logic          ex_ones, ex_zero, mn_zero;

  assign sgn     = x[EW+MW];
  assign ex      = x[MW +: EW];
  assign mn      = x[MW-1:0];
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign mn_zero = ~|mn;

  always_comb begin
    cls = '0;
    if (ex_ones) begin
      if (mn_zero) cls[sgn ? 0 : 7] = 1'b1;
      else         cls[mn[MW-1] ? 9 : 8] = 1'b1;
    end else if (ex_zero) begin
      if (mn_zero) cls[sgn ? 3 : 4] = 1'b1;
      else         cls[sgn ? 2 : 5] = 1'b1;
    end else begin
      cls[sgn ? 1 : 6] = 1'b1;
    end
  end
endmodule

// File: rtl/vfc_seq.sv
module vfc_seq #(
  parameter int VLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] lim_in,
  output logic           busy,
  output logic [VLW-1:0] idx,
  output logic           last,
  output logic           done
);
  logic [VLW-1:0] lim_q;

  assign last = busy && (idx == lim_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      lim_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          idx   <= '0;
          lim_q <= lim_in;
        end
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R9: the walk is never restarted by start while busy
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && idx == $past(idx) + 1'b1));
  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: done only follows the final index
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last));
endmodule

// File: rtl/vfc_unit.sv
module vfc_unit
  import vfc_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int MAXE  = VLEN / 16,
  parameter int VLW   = $clog2(MAXE + 1),
  parameter int IW    = (MAXE > 1) ? $clog2(MAXE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      sew_sel,
  input  logic [VLW-1:0]  vl,
  input  logic            vm,
  input  logic [MAXE-1:0] mask,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] dst_in,
  output logic [VLEN-1:0] dst_out,
  output logic            done
);
  localparam logic [VLW-1:0] MAXE_V = VLW'(MAXE);

  logic [VLEN-1:0] src_q, dst_q;
  logic [MAXE-1:0] mask_q;
  logic [VLW-1:0]  vl_q;
  logic            vm_q;
  sew_e            sew_q;

  logic            busy, last;
  logic [VLW-1:0]  idx;
  logic [VLW-1:0]  lim_in;
  logic            accept;
  logic [63:0]     raw;
  logic [9:0]      cls_fmt [3];
  logic [9:0]      cls;
  logic            in_body, active;
  logic [63:0]     wr_val;

  function automatic logic [63:0] pick(input logic [VLEN-1:0] v,
                                       input logic [VLW-1:0] i, input sew_e s);
    case (s)
      SEW16:   return {48'd0, v[int'(i)*16 +: 16]};
      SEW32:   return {32'd0, v[int'(i)*32 +: 32]};
      default: return v[int'(i)*64 +: 64];
    endcase
  endfunction

  assign lim_in = MAXE_V >> width_shift(sew_e'(sew_sel));
  assign accept = start && !busy;

  vfc_seq #(.VLW(VLW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lim_in(lim_in),
    .busy(busy), .idx(idx), .last(last), .done(done)
  );

  assign raw = pick(src_q, idx, sew_q);

  for (genvar f = 0; f < 3; f++) begin : g_fmt
    localparam int EW = exp_w(f);
    localparam int MW = man_w(f);
    vfc_classify #(.EW(EW), .MW(MW)) cls_i (
      .x(raw[EW+MW:0]), .cls(cls_fmt[f])
    );
  end

  assign cls     = cls_fmt[width_shift(sew_q)];
  assign in_body = idx < vl_q;
  assign active  = vm_q || mask_q[idx[IW-1:0]];
  assign wr_val  = in_body ? {54'd0, cls} : 64'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      mask_q <= '0;
      vl_q   <= '0;
      vm_q   <= 1'b1;
      sew_q  <= SEW16;
    end else if (accept) begin
      src_q  <= src_vec;
      dst_q  <= dst_in;
      mask_q <= mask;
      vl_q   <= vl;
      vm_q   <= vm;
      sew_q  <= sew_e'(sew_sel);
    end else if (busy && !(in_body && !active)) begin
      case (sew_q)
        SEW16:   dst_q[int'(idx)*16 +: 16] <= wr_val[15:0];
        SEW32:   dst_q[int'(idx)*32 +: 32] <= wr_val[31:0];
        default: dst_q[int'(idx)*64 +: 64] <= wr_val;
      endcase
    end
  end

  assign dst_out = dst_q;

  // R8: a tail element reads zero right after its cycle
  a_r8_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_body) |=> (pick(dst_q, $past(idx), sew_q) == 64'd0));
  // R7: a masked-off element is left untouched
  a_r7_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_body && !active) |=>
      (pick(dst_q, $past(idx), sew_q) == $past(pick(dst_q, idx, sew_q))));
  // R6: an active element holds exactly one code bit, zero-extended
  a_r6_onehot_code: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_body && active) |=> $onehot(pick(dst_q, $past(idx), sew_q)));
endmodule

// File: tb/vfc_unit_tb_top.sv
module vfc_unit_tb_top;
  localparam int VLEN = 128;
  localparam int MAXE = VLEN / 16;
  localparam int VLW  = $clog2(MAXE + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      sew_sel = '0;
  logic [VLW-1:0]  vl = '0;
  logic            vm = 1'b1;
  logic [MAXE-1:0] mask = '0;
  logic [VLEN-1:0] src_vec = '0;
  logic [VLEN-1:0] dst_in = '0;
  logic [VLEN-1:0] dst_out;
  logic            done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vfc_unit #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sew_sel(sew_sel), .vl(vl),
    .vm(vm), .mask(mask), .src_vec(src_vec), .dst_in(dst_in),
    .dst_out(dst_out), .done(done)
  );

  function automatic int ew_of(int s); return s == 0 ? 5 : s == 1 ? 8 : 11; endfunction
  function automatic int mw_of(int s); return s == 0 ? 10 : s == 1 ? 23 : 52; endfunction
  function automatic int w_of(int s);  return 16 << s; endfunction

  // cat: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN
  function automatic logic [63:0] mk(int s, bit sg, int cat);
    int ew = ew_of(s); int mw = mw_of(s);
    logic [63:0] mmask = (64'd1 << mw) - 1;
    logic [63:0] emax  = (64'd1 << ew) - 1;
    logic [63:0] man   = {$urandom, $urandom} & mmask;
    logic [63:0] ex;
    case (cat)
      0: begin ex = 0; man = 0; end
      1: begin ex = 0; if (man == 0) man = 1; end
      2: ex = 64'(1 + ($urandom % (emax - 1)));
      3: begin ex = emax; man = 0; end
      4: begin ex = emax; man = man | (64'd1 << (mw - 1)); end
      default: begin ex = emax; man = (man & ~(64'd1 << (mw - 1))) | 64'd1; end
    endcase
    return (64'(sg) << (ew + mw)) | (ex << mw) | man;
  endfunction

  function automatic logic [9:0] ref_cls(logic [63:0] v, int s);
    int ew = ew_of(s); int mw = mw_of(s);
    logic [63:0] man = v & ((64'd1 << mw) - 1);
    logic [63:0] ex  = (v >> mw) & ((64'd1 << ew) - 1);
    bit sg = v[ew + mw];
    bit top = v[mw - 1];
    if (ex == (64'd1 << ew) - 1 && man != 0) return top ? 10'h200 : 10'h100;
    if (ex == (64'd1 << ew) - 1)             return sg ? 10'h001 : 10'h080;
    if (ex == 0 && man == 0)                 return sg ? 10'h008 : 10'h010;
    if (ex == 0)                             return sg ? 10'h004 : 10'h020;
    return sg ? 10'h002 : 10'h040;
  endfunction

  function automatic logic [63:0] get_e(logic [VLEN-1:0] v, int i, int s);
    return (v >> (i * w_of(s))) & ((s == 2) ? {64{1'b1}} : ((64'd1 << w_of(s)) - 1));
  endfunction

  function automatic logic [VLEN-1:0] ref_vec(int s, int n, bit m, logic [MAXE-1:0] mk_v,
                                              logic [VLEN-1:0] src, logic [VLEN-1:0] din);
    logic [VLEN-1:0] r = '0;
    int lim = MAXE >> s;
    for (int i = 0; i < lim; i++) begin
      logic [63:0] e = 0;
      if (i < n) e = (m || mk_v[i]) ? 64'(ref_cls(get_e(src, i, s), s)) : get_e(din, i, s);
      r = r | (VLEN'(e) << (i * w_of(s)));
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(int s, int n, bit m, logic [MAXE-1:0] mk_v, logic [VLEN-1:0] src,
                        logic [VLEN-1:0] din, string tag, bit poke);
    logic [VLEN-1:0] exp = ref_vec(s, n, m, mk_v, src, din);
    int cnt = 0;
    @(negedge clk);
    sew_sel = 2'(s); vl = VLW'(n); vm = m; mask = mk_v; src_vec = src; dst_in = din;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 100) begin
      if (poke && cnt == 1) begin
        start = 1'b1; sew_sel = 2'd0; vl = VLW'(MAXE); vm = 1'b1;
        src_vec = ~src; dst_in = ~din;
      end else start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(cnt == (MAXE >> s), "R9 latency", VLEN'(cnt), VLEN'(MAXE >> s));
    chk(dst_out == exp, tag, dst_out, exp);
    @(negedge clk);
    chk(!done, "R9 done single cycle", VLEN'(done), '0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string tags[6] = '{"R2 zero", "R3 subnormal", "R4 normal", "R1 infinity",
                       "R5 quiet NaN", "R5 signaling NaN"};
    void'($urandom(32'h5EED_0C1A));
    repeat (3) @(negedge clk);
    chk(dst_out == '0 && !done, "reset state", dst_out, '0);
    rst_n = 1'b1;

    // directed: every category, every width (R6), both signs
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 6; c++) begin
        logic [VLEN-1:0] src = '0;
        for (int i = 0; i < (MAXE >> s); i++)
          src = src | (VLEN'(mk(s, i[0], c)) << (i * w_of(s)));
        run_op(s, MAXE >> s, 1'b1, '0, src, {$urandom, $urandom, $urandom, $urandom},
               $sformatf("%s R6 sew=%0d", tags[c], s), 1'b0);
      end
    end

    // R7 mask keeps old contents
    run_op(0, MAXE, 1'b0, 8'b1010_0101, {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, "R7 masked keep", 1'b0);
    // R8 tail cleared
    run_op(1, 2, 1'b1, '0, {$urandom, $urandom, $urandom, $urandom}, '1, "R8 tail clear", 1'b0);
    // R10 empty length
    run_op(2, 0, 1'b0, '1, {$urandom, $urandom, $urandom, $urandom}, '1, "R10 vl zero", 1'b0);
    // R9 start during busy ignored
    run_op(0, 5, 1'b0, 8'b0110_1100, {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, "R9 start ignored", 1'b1);

    // constrained random mix
    for (int t = 0; t < 60; t++) begin
      int s = $urandom % 3;
      int n = $urandom % ((MAXE >> s) + 1);
      logic [VLEN-1:0] src = '0;
      for (int i = 0; i < (MAXE >> s); i++)
        src = src | (VLEN'(mk(s, 1'($urandom), $urandom % 6)) << (i * w_of(s)));
      run_op(s, n, 1'($urandom), MAXE'($urandom), src,
             {$urandom, $urandom, $urandom, $urandom}, "R7 R8 random", 1'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule